// File: doc/BRIEF.md
# Prioritized Interrupt Arbiter with Context Capture

This block gathers interrupt requests from two serial channels, each of which offers nine request sources, for eighteen in all. Every source carries an 8-bit bid that software may rewrite at any time. Each cycle a two-level arbiter picks the source with the highest non-zero bid among those requesting. The interrupt line is raised while that winning bid is above a programmable threshold.

When the host acknowledges the interrupt, or writes the update command, the current winner is latched into a context register. The context holds the channel, the source type and, for receiver or transmitter sources, that FIFO's fill level. It stays frozen until the next capture. The context drives three things. It shapes an interrupt vector from a base value under two substitution switches. It drives a channel-select output. It also sets the channel reached by the fixed global FIFO-level reads, so service code can work without first decoding which channel interrupted.

Top module: `irq_arb`

## Requirements
- R1: Among sources whose request is high and whose bid is non-zero, the one with the largest bid wins. Source s belongs to channel s/9 and has type s%9.
- R2: When bids are equal, the lower source number wins.
- R3: A source whose bid is zero never wins, whatever its request.
- R4: `irq_o` is high only while a winner exists and its bid is strictly greater than the threshold register (offset 0x20).
- R5: `iack_i` high at a rising edge latches the winner present in that cycle into the context (`ctx_ch_o`, `ctx_type_o`). The context byte read at offset 0x24 is {channel, type[3:0]}.
- R6: Writing any data to offset 0x23 captures exactly as an acknowledge does. If both happen in one cycle, a single capture takes place.
- R7: The context does not change between captures, even after the captured request is withdrawn.
- R8: `ctx_fill_o` latches the channel's receive fill for type 0, the channel's transmit fill for type 1, and 0 for every other type.
- R9: `vector_o` starts from the base register (offset 0x21). Mode bit 0 (offset 0x22) puts the type into vector bits [3:0], and mode bit 1 puts the channel into bit 4.
- R10: A capture with no winner stores type 0xF, channel 0 and fill 0, clears `ctx_valid_o`, and leaves `vector_o` equal to the unmodified base.
- R11: `gsel_ch_o` equals the captured channel. Reads at 0x26 and 0x27 return that channel's receive and transmit fill.
- R12: After reset, all bids (offsets 0x00 to 0x11), the threshold, the base and the mode are 0, and the context reads as no interrupt.
- R13: A bid write at the same edge as a capture takes effect after it, so the capture sees the old bid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 18 | Request per source, source s = channel*9 + type |
| rx_fill_i | input | 16 | Receive FIFO fill, 8 bits per channel |
| tx_fill_i | input | 16 | Transmit FIFO fill, 8 bits per channel |
| iack_i | input | 1 | Interrupt acknowledge strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 6 | Register offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |
| vector_o | output | 8 | Interrupt vector |
| ctx_valid_o | output | 1 | Context holds a real source |
| ctx_ch_o | output | 1 | Captured channel |
| ctx_type_o | output | 4 | Captured source type, 0xF for none |
| ctx_fill_o | output | 8 | Captured FIFO fill |
| gsel_ch_o | output | 1 | Channel select for global reads |

## Verification
Two functions can land on the same edge: a capture, and a register write that alters what is being captured. The first case is a bid write issued in the same cycle as the acknowledge. The second is the update command issued in the same cycle as the acknowledge. In the first case the bench expects the winner chosen under the old bids, and the next acknowledge must show the new order. In the second case it expects exactly one scoreboard entry, and any extra or missing capture shows up as a mismatch or a non-empty queue.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // source types inside a channel
  localparam int TYPE_RX = 0;
  localparam int TYPE_TX = 1;
  // vector mode bits
  localparam int VM_TYPE = 0;
  localparam int VM_CH   = 1;
  localparam int VM_W    = 2;
  // register offsets (bids occupy 0 .. N_SRC-1)
  localparam int A_THR   = 32;
  localparam int A_VBASE = 33;
  localparam int A_VMODE = 34;
  localparam int A_UPD   = 35;
  localparam int A_CIR   = 36;
  localparam int A_CFILL = 37;
  localparam int A_GRX   = 38;
  localparam int A_GTX   = 39;
endpackage

// File: rtl/irq_bid_regs.sv
module irq_bid_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC  = 18,
  parameter int BID_W  = 8,
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [DATA_W-1:0]      wdata_i,
  output logic [N_SRC*BID_W-1:0] bids_o,
  output logic [BID_W-1:0]       thresh_o,
  output logic [DATA_W-1:0]      vbase_o,
  output logic [VM_W-1:0]        vmode_o,
  output logic                   upd_o
);
  localparam logic [ADDR_W-1:0] ADR_THR = ADDR_W'(A_THR);
  localparam logic [ADDR_W-1:0] ADR_VB  = ADDR_W'(A_VBASE);
  localparam logic [ADDR_W-1:0] ADR_VM  = ADDR_W'(A_VMODE);
  localparam logic [ADDR_W-1:0] ADR_UPD = ADDR_W'(A_UPD);

  for (genvar g = 0; g < N_SRC; g++) begin : g_bid
    logic [BID_W-1:0] bid_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) bid_q <= '0;
      else if (we_i && addr_i == ADDR_W'(g)) bid_q <= wdata_i[BID_W-1:0];
    end
    assign bids_o[g*BID_W +: BID_W] = bid_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thresh_o <= '0;
      vbase_o  <= '0;
      vmode_o  <= '0;
    end else if (we_i) begin
      if (addr_i == ADR_THR) thresh_o <= wdata_i[BID_W-1:0];
      if (addr_i == ADR_VB)  vbase_o  <= wdata_i;
      if (addr_i == ADR_VM)  vmode_o  <= wdata_i[VM_W-1:0];
    end
  end

  assign upd_o = we_i && (addr_i == ADR_UPD);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int N     = 9,
  parameter int BID_W = 8,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]       req_i,
  input  logic [N*BID_W-1:0] bids_i,
  output logic               valid_o,
  output logic [IDX_W-1:0]   idx_o,
  output logic [BID_W-1:0]   bid_o
);
  // strict compare from low index keeps the lowest index on ties;
  // starting at zero excludes zero bids
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    bid_o   = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && bids_i[i*BID_W +: BID_W] > bid_o) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        bid_o   = bids_i[i*BID_W +: BID_W];
      end
    end
  end
endmodule

// File: rtl/irq_ctx.sv
module irq_ctx
  import irq_arb_pkg::*;
#(
  parameter int N_CH   = 2,
  parameter int FILL_W = 8,
  parameter int TYPE_W = 4,
  parameter int CH_W   = 1,
  parameter int VEC_W  = 8
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cap_i,
  input  logic                   win_valid_i,
  input  logic [CH_W-1:0]        win_ch_i,
  input  logic [TYPE_W-1:0]      win_type_i,
  input  logic [N_CH*FILL_W-1:0] rx_fill_i,
  input  logic [N_CH*FILL_W-1:0] tx_fill_i,
  input  logic [VEC_W-1:0]       vbase_i,
  input  logic [VM_W-1:0]        vmode_i,
  output logic                   valid_o,
  output logic [CH_W-1:0]        ch_o,
  output logic [TYPE_W-1:0]      type_o,
  output logic [FILL_W-1:0]      fill_o,
  output logic [VEC_W-1:0]       vector_o
);
  localparam logic [TYPE_W-1:0] T_NONE = '1;

  logic [FILL_W-1:0] fill_sel;

  always_comb begin
    fill_sel = '0;
    if (int'(win_type_i) == TYPE_RX) fill_sel = rx_fill_i[int'(win_ch_i)*FILL_W +: FILL_W];
    if (int'(win_type_i) == TYPE_TX) fill_sel = tx_fill_i[int'(win_ch_i)*FILL_W +: FILL_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ch_o    <= '0;
      type_o  <= T_NONE;
      fill_o  <= '0;
    end else if (cap_i) begin
      valid_o <= win_valid_i;
      ch_o    <= win_valid_i ? win_ch_i : '0;
      type_o  <= win_valid_i ? win_type_i : T_NONE;
      fill_o  <= win_valid_i ? fill_sel : '0;
    end
  end

  always_comb begin
    vector_o = vbase_i;
    if (valid_o) begin
      if (vmode_i[VM_TYPE]) vector_o[TYPE_W-1:0]   = type_o;
      if (vmode_i[VM_CH])   vector_o[TYPE_W +: CH_W] = ch_o;
    end
  end
endmodule

// File: rtl/irq_arb.sv
module irq_arb
  import irq_arb_pkg::*;
#(
  parameter int N_CH       = 2,
  parameter int SRC_PER_CH = 9,
  parameter int BID_W      = 8,
  parameter int FILL_W     = 8,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 8,
  localparam int N_SRC     = N_CH * SRC_PER_CH,
  localparam int TYPE_W    = $clog2(SRC_PER_CH + 1),
  localparam int CH_W      = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_CH*FILL_W-1:0] rx_fill_i,
  input  logic [N_CH*FILL_W-1:0] tx_fill_i,
  input  logic                   iack_i,
  input  logic                   reg_we_i,
  input  logic [ADDR_W-1:0]      reg_addr_i,
  input  logic [DATA_W-1:0]      reg_wdata_i,
  output logic [DATA_W-1:0]      reg_rdata_o,
  output logic                   irq_o,
  output logic [DATA_W-1:0]      vector_o,
  output logic                   ctx_valid_o,
  output logic [CH_W-1:0]        ctx_ch_o,
  output logic [TYPE_W-1:0]      ctx_type_o,
  output logic [FILL_W-1:0]      ctx_fill_o,
  output logic [CH_W-1:0]        gsel_ch_o
);
  localparam logic [ADDR_W-1:0] ADR_THR = ADDR_W'(A_THR);
  localparam logic [ADDR_W-1:0] ADR_VB  = ADDR_W'(A_VBASE);
  localparam logic [ADDR_W-1:0] ADR_VM  = ADDR_W'(A_VMODE);
  localparam logic [ADDR_W-1:0] ADR_CIR = ADDR_W'(A_CIR);
  localparam logic [ADDR_W-1:0] ADR_CF  = ADDR_W'(A_CFILL);
  localparam logic [ADDR_W-1:0] ADR_GRX = ADDR_W'(A_GRX);
  localparam logic [ADDR_W-1:0] ADR_GTX = ADDR_W'(A_GTX);

  logic [N_SRC*BID_W-1:0] bids;
  logic [BID_W-1:0]       thresh;
  logic [DATA_W-1:0]      vbase;
  logic [VM_W-1:0]        vmode;
  logic                   upd;
  logic                   cap;

  irq_bid_regs #(
    .N_SRC (N_SRC),
    .BID_W (BID_W),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .bids_o  (bids),
    .thresh_o(thresh),
    .vbase_o (vbase),
    .vmode_o (vmode),
    .upd_o   (upd)
  );

  // level 1: one picker per channel
  logic [N_CH-1:0]        ch_valid;
  logic [N_CH*BID_W-1:0]  ch_bid;
  logic [N_CH*TYPE_W-1:0] ch_type;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    irq_pick #(
      .N    (SRC_PER_CH),
      .BID_W(BID_W),
      .IDX_W(TYPE_W)
    ) u_pick (
      .req_i  (req_i[c*SRC_PER_CH +: SRC_PER_CH]),
      .bids_i (bids[c*SRC_PER_CH*BID_W +: SRC_PER_CH*BID_W]),
      .valid_o(ch_valid[c]),
      .idx_o  (ch_type[c*TYPE_W +: TYPE_W]),
      .bid_o  (ch_bid[c*BID_W +: BID_W])
    );
  end

  // level 2: across channels, lower channel wins ties
  logic              win_valid;
  logic [CH_W-1:0]   win_ch;
  logic [BID_W-1:0]  win_bid;
  logic [TYPE_W-1:0] win_type;

  irq_pick #(
    .N    (N_CH),
    .BID_W(BID_W),
    .IDX_W(CH_W)
  ) u_pick_ch (
    .req_i  (ch_valid),
    .bids_i (ch_bid),
    .valid_o(win_valid),
    .idx_o  (win_ch),
    .bid_o  (win_bid)
  );

  assign win_type = ch_type[int'(win_ch)*TYPE_W +: TYPE_W];
  assign irq_o    = win_valid && (win_bid > thresh);
  assign cap      = iack_i || upd;

  irq_ctx #(
    .N_CH  (N_CH),
    .FILL_W(FILL_W),
    .TYPE_W(TYPE_W),
    .CH_W  (CH_W),
    .VEC_W (DATA_W)
  ) u_ctx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap),
    .win_valid_i(win_valid),
    .win_ch_i   (win_ch),
    .win_type_i (win_type),
    .rx_fill_i  (rx_fill_i),
    .tx_fill_i  (tx_fill_i),
    .vbase_i    (vbase),
    .vmode_i    (vmode),
    .valid_o    (ctx_valid_o),
    .ch_o       (ctx_ch_o),
    .type_o     (ctx_type_o),
    .fill_o     (ctx_fill_o),
    .vector_o   (vector_o)
  );

  assign gsel_ch_o = ctx_ch_o;

  always_comb begin
    reg_rdata_o = '0;
    if (int'(reg_addr_i) < N_SRC) begin
      reg_rdata_o = DATA_W'(bids[int'(reg_addr_i)*BID_W +: BID_W]);
    end else begin
      case (reg_addr_i)
        ADR_THR: reg_rdata_o = DATA_W'(thresh);
        ADR_VB:  reg_rdata_o = vbase;
        ADR_VM:  reg_rdata_o = DATA_W'(vmode);
        ADR_CIR: reg_rdata_o = DATA_W'({ctx_ch_o, ctx_type_o});
        ADR_CF:  reg_rdata_o = DATA_W'(ctx_fill_o);
        ADR_GRX: reg_rdata_o = DATA_W'(rx_fill_i[int'(gsel_ch_o)*FILL_W +: FILL_W]);
        ADR_GTX: reg_rdata_o = DATA_W'(tx_fill_i[int'(gsel_ch_o)*FILL_W +: FILL_W]);
        default: reg_rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk
  import irq_arb_pkg::*;
#(
  parameter int N_CH       = 2,
  parameter int SRC_PER_CH = 9,
  parameter int BID_W      = 8,
  parameter int FILL_W     = 8,
  parameter int TYPE_W     = 4,
  parameter int CH_W       = 1,
  parameter int VEC_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cap_i,
  input logic [N_CH-1:0]   ch_valid_i,
  input logic              win_valid_i,
  input logic [BID_W-1:0]  win_bid_i,
  input logic [BID_W-1:0]  thresh_i,
  input logic              irq_i,
  input logic [CH_W-1:0]   ctx_ch_i,
  input logic [TYPE_W-1:0] ctx_type_i,
  input logic [FILL_W-1:0] ctx_fill_i,
  input logic [VEC_W-1:0]  vector_i,
  input logic [VEC_W-1:0]  vbase_i
);
  localparam logic [TYPE_W-1:0] T_NONE = '1;

  p_any_ch_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ch_valid_i) |-> win_valid_i);

  p_zero_bid_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    win_valid_i |-> (win_bid_i != '0));

  p_irq_thresh_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (win_valid_i && win_bid_i > thresh_i));

  p_none_cap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && !win_valid_i) |=> (ctx_type_i == T_NONE));

  p_type_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ctx_type_i) < SRC_PER_CH) || (ctx_type_i == T_NONE));

  p_ctx_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap_i |=> ($stable(ctx_ch_i) && $stable(ctx_type_i) && $stable(ctx_fill_i)));

  p_fill_other_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(ctx_type_i) > TYPE_TX) |-> (ctx_fill_i == '0));

  p_none_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_type_i == T_NONE) |-> (vector_i == vbase_i));
endmodule

bind irq_arb irq_arb_chk #(
  .N_CH      (N_CH),
  .SRC_PER_CH(SRC_PER_CH),
  .BID_W     (BID_W),
  .FILL_W    (FILL_W),
  .TYPE_W    (TYPE_W),
  .CH_W      (CH_W),
  .VEC_W     (DATA_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cap_i      (cap),
  .ch_valid_i (ch_valid),
  .win_valid_i(win_valid),
  .win_bid_i  (win_bid),
  .thresh_i   (thresh),
  .irq_i      (irq_o),
  .ctx_ch_i   (ctx_ch_o),
  .ctx_type_i (ctx_type_o),
  .ctx_fill_i (ctx_fill_o),
  .vector_i   (vector_o),
  .vbase_i    (vbase)
);

// File: tb/irq_arb_bench.sv
module irq_arb_bench;
  import irq_arb_pkg::*;

  localparam int NS  = 18;
  localparam int SPC = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [NS-1:0] req   = '0;
  logic [15:0]   rxf   = {8'h42, 8'h21};
  logic [15:0]   txf   = {8'h7E, 8'h13};
  logic          iack  = 1'b0;
  logic          we    = 1'b0;
  logic [5:0]    addr  = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          irq;
  logic [7:0]    vec;
  logic          cval;
  logic [0:0]    cch;
  logic [3:0]    cty;
  logic [7:0]    cfill;
  logic [0:0]    gsel;

  irq_arb u_irq_arb (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .req_i      (req),
    .rx_fill_i  (rxf),
    .tx_fill_i  (txf),
    .iack_i     (iack),
    .reg_we_i   (we),
    .reg_addr_i (addr),
    .reg_wdata_i(wdata),
    .reg_rdata_o(rdata),
    .irq_o      (irq),
    .vector_o   (vec),
    .ctx_valid_o(cval),
    .ctx_ch_o   (cch),
    .ctx_type_o (cty),
    .ctx_fill_o (cfill),
    .gsel_ch_o  (gsel)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic [7:0] bm [NS];
  logic [7:0] vbm = '0;
  logic [1:0] vmm = '0;

  typedef struct {
    string      tag;
    logic [7:0] cir;
    logic [7:0] fill;
    logic [7:0] vec;
  } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic exp_t model(input string tag);
    exp_t e;
    int w = -1;
    int best = 0;
    int ch, ty;
    for (int i = 0; i < NS; i++)
      if (req[i] && int'(bm[i]) > best) begin
        best = int'(bm[i]);
        w = i;
      end
    e.tag = tag;
    if (w < 0) begin
      e.cir = 8'h0F; e.fill = 8'h00; e.vec = vbm;
    end else begin
      ch = w / SPC; ty = w % SPC;
      e.cir  = 8'((ch << 4) | ty);
      e.fill = (ty == 0) ? rxf[ch*8 +: 8] : (ty == 1) ? txf[ch*8 +: 8] : 8'h00;
      e.vec  = vbm;
      if (vmm[0]) e.vec[3:0] = 4'(ty);
      if (vmm[1]) e.vec[4]   = 1'(ch);
    end
    return e;
  endfunction

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = 6'(a); wdata = d;
    @(negedge clk);
    we = 1'b0;
    if (a < NS) bm[a] = d;
    if (a == A_VBASE) vbm = d;
    if (a == A_VMODE) vmm = d[1:0];
  endtask

  task automatic ack(input string tag);
    @(negedge clk);
    iack = 1'b1;
    sbq.push_back(model(tag));
    @(negedge clk);
    iack = 1'b0;
  endtask

  task automatic upd(input string tag);
    @(negedge clk);
    we = 1'b1; addr = 6'(A_UPD);
    sbq.push_back(model(tag));
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic ack_upd(input string tag);
    @(negedge clk);
    iack = 1'b1; we = 1'b1; addr = 6'(A_UPD);
    sbq.push_back(model(tag));
    @(negedge clk);
    iack = 1'b0; we = 1'b0;
  endtask

  task automatic ack_bidwr(input string tag, input int a, input logic [7:0] d);
    @(negedge clk);
    iack = 1'b1; we = 1'b1; addr = 6'(a); wdata = d;
    sbq.push_back(model(tag));
    bm[a] = d;
    @(negedge clk);
    iack = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = 6'(a);
    #1 d = rdata;
  endtask

  task automatic set_req(input logic [NS-1:0] v);
    @(negedge clk);
    req = v;
    #1;
  endtask

  // monitor: compares the context one half-cycle after each capture edge
  logic pend = 1'b0;
  always @(posedge clk) pend <= iack || (we && addr == 6'(A_UPD));
  always @(negedge clk) begin
    if (pend) begin
      if (sbq.size() == 0) begin
        check("R6 unexpected capture", 1, 0);
      end else begin
        mon_e = sbq.pop_front();
        check({mon_e.tag, " cir"},  {24'h0, 3'b0, cch, cty}, {24'h0, mon_e.cir});
        check({mon_e.tag, " fill"}, {24'h0, cfill},          {24'h0, mon_e.fill});
        check({mon_e.tag, " vec"},  {24'h0, vec},            {24'h0, mon_e.vec});
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  logic [7:0] d;
  initial begin
    for (int i = 0; i < NS; i++) bm[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R12 reset state
    check("R12 ctx type", cty, 4'hF);
    check("R12 ctx valid", cval, 0);
    check("R12 irq", irq, 0);
    check("R12 vector", vec, 0);
    rd(A_CIR, d); check("R12 cir read", d, 8'h0F);
    rd(0, d);     check("R12 bid0", d, 0);
    rd(A_THR, d); check("R12 threshold", d, 0);

    // R3 zero bids never win
    set_req('1);
    check("R3 irq with zero bids", irq, 0);
    ack("R3 zero bids capture none");

    for (int i = 0; i < NS; i++) wr(i, 8'(8'h10 + i * 3));
    set_req('1);
    check("R4 irq above zero threshold", irq, 1);
    ack("R1 R5 all requesting");

    // R8 fill selection
    set_req(NS'(1) << 9);
    ack("R8 rx fill ch1");
    set_req(NS'(1) << 1);
    ack("R8 tx fill ch0");

    // R1 assorted patterns
    set_req(18'h00F0F); ack("R1 pattern a");
    set_req(18'h30001); ack("R1 pattern b");
    set_req(18'h05555); ack("R1 pattern c");
    set_req(18'h2AAAA); ack("R1 pattern d");
    set_req(18'h10200); ack("R1 pattern e");
    set_req(18'h00006); ack("R1 pattern f");

    // R2 ties
    wr(3, 8'hC8);
    wr(12, 8'hC8);
    set_req((NS'(1) << 3) | (NS'(1) << 12) | (NS'(1) << 17));
    ack("R2 tie goes to lower index");
    wr(12, 8'hC9);
    ack("R2 higher bid overrides index");

    // R4 threshold
    set_req(NS'(1) << 5);
    wr(A_THR, 8'h1F); #1;
    check("R4 bid equal to threshold", irq, 0);
    wr(A_THR, 8'h1E); #1;
    check("R4 bid above threshold", irq, 1);
    set_req('0);
    check("R4 no request", irq, 0);
    wr(A_THR, 8'h00);

    // R7 hold after request drops, R11 global reads
    set_req(NS'(1) << 12);
    ack("R7 capture");
    set_req('0);
    repeat (5) @(negedge clk);
    #1;
    check("R7 type held", cty, 4'd3);
    check("R7 channel held", cch, 1);
    check("R7 valid held", cval, 1);
    check("R11 gsel ch1", gsel, 1);
    rd(A_GRX, d); check("R11 global rx ch1", d, 8'h42);
    rd(A_GTX, d); check("R11 global tx ch1", d, 8'h7E);
    rd(A_CIR, d); check("R5 cir read", d, 8'h13);
    set_req(NS'(1) << 2);
    ack("R11 capture ch0");
    #1;
    check("R11 gsel ch0", gsel, 0);
    rd(A_GRX, d); check("R11 global rx ch0", d, 8'h21);
    rd(A_GTX, d); check("R11 global tx ch0", d, 8'h13);

    // R9 vector modes, captured by update command (R6)
    set_req(NS'(1) << 12);
    wr(A_VBASE, 8'hA0);
    for (int m = 0; m < 4; m++) begin
      wr(A_VMODE, 8'(m));
      upd("R9 R6 vector mode");
    end
    #1;
    check("R9 both fields substituted", vec, 8'hB3);

    // R10 none capture with modification enabled
    set_req('0);
    upd("R10 none capture");
    #1;
    check("R10 valid cleared", cval, 0);
    check("R10 vector unmodified", vec, 8'hA0);

    // R6 ack and update together: one capture
    set_req(NS'(1) << 7);
    ack_upd("R6 ack with update");

    // R13 bid write at the capture edge
    wr(4, 8'h50);
    wr(6, 8'h40);
    set_req((NS'(1) << 4) | (NS'(1) << 6));
    ack_bidwr("R13 capture sees old bids", 6, 8'h90);
    ack("R13 new bid effective next");

    repeat (3) @(negedge clk);
    check("R6 scoreboard drained", sbq.size(), 0);
    finish_run();
  end
endmodule